// File: doc/BRIEF.md
# Period-Match Timer with Prescale and Postscale

An 8-bit up-counting timer for a peripheral subsystem. A prescaler gates the counter and divides the incoming instruction-clock enable by 1, 4 or 16. The counter steps once per prescaler output. At every step the count is compared with a period register. When the count equals the period, that step returns the count to 00h instead of adding one, and a one-cycle match pulse is produced. A downstream serial shifter can use this pulse as its shift clock.

Each match also advances a postscaler. When the postscaler has seen the programmed number of matches, it sets a sticky interrupt flag and starts counting again. Software reaches the control, count and period registers through a simple write port with a separate combinational read port. Writing the count or control register restarts both the prescaler and the postscaler.

Top module: `tmr_period_match`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control reads 00h, and irq_o and match_o are 0.
- R2: Register addresses are 0 = control, 1 = count and 2 = period. Address 3 reads 00h and ignores writes. Bit 7 of the control register always reads 0.
- R3: Control bits [1:0] set the prescale ratio: 00 gives 1, 01 gives 4, and 10 or 11 give 16. The counter steps once for every that-many cycles with tick_i high.
- R4: The counter advances only while control bit 2 is 1 and tick_i is 1. Otherwise it holds its value.
- R5: At a counter step where the count equals the period, the count becomes 00h. match_o is then high for exactly the one following cycle. At any other step the count increases by one.
- R6: Control bits [6:3] hold a value v. irq_o sets after v+1 matches, counted from the last restart of the postscaler.
- R7: irq_o stays set until irq_clr_i is asserted. If a set and a clear fall in the same cycle, the set wins.
- R8: A write to the count register or to the control register clears the prescaler and postscaler counters. No counter step occurs in that cycle.
- R9: A count-register write loads the written value next cycle and takes priority over a step in the same cycle. A control-register write leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |
| match_o | output | 1 | One-cycle pulse per period match |

## Verification
Two functions can fall in the same cycle: a software write to the count register and a counter step. To provoke this, the bench runs the counter at prescale 1 with tick_i held high and writes a new count. The write must win: the count read next cycle is exactly the written value, not that value plus one. A sweep over every prescale code, several periods and several postscale values then compares the exact cycle at which irq_o rises, and the number of match pulses seen up to that point, against divider × (period+1) × (postscale+1).

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_CNT  = 2'd1;
  localparam logic [AW-1:0] ADDR_PER  = 2'd2;

  typedef struct packed {
    logic [3:0] post_sel;
    logic       run;
    logic [1:0] pre_sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned MID_LOG2 = 2,
  parameter int unsigned MAX_LOG2 = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  localparam int unsigned CW = MAX_LOG2;
  localparam logic [CW-1:0] LIM_MID = CW'((1 << MID_LOG2) - 1);
  localparam logic [CW-1:0] LIM_MAX = CW'((1 << MAX_LOG2) - 1);

  logic [CW-1:0] cnt_q, limit;

  always_comb begin
    unique case (sel_i)
      2'b00:   limit = '0;
      2'b01:   limit = LIM_MID;
      default: limit = LIM_MAX;
    endcase
  end

  assign step_o = tick_i && !clr_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  // R3
  pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         match_evt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic         match_q;

  assign match_evt_o = step_i && !load_i && (cnt_q == period_i);
  assign cnt_o       = cnt_q;
  assign match_o     = match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_evt_o;
      if (load_i)           cnt_q <= load_val_i;
      else if (match_evt_o) cnt_q <= '0;
      else if (step_i)      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  // R5
  match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> cnt_q == '0);
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          match_i,
  input  logic [SW-1:0] sel_i,
  input  logic          irq_clr_i,
  output logic          irq_o
);
  logic [SW-1:0] cnt_q;
  logic          irq_q, done;

  assign done  = match_i && !clr_i && (cnt_q == sel_i);
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (match_i) cnt_q <= done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (done)      irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(match_i));
endmodule

// File: rtl/tmr_period_match.sv
module tmr_period_match
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic          match_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] period_q, cnt;
  logic          wr_ctrl, wr_cnt, wr_per, clr_scale, pre_tick, step, match_evt;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_cnt    = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign wr_per    = wr_en_i && (wr_addr_i == ADDR_PER);
  assign clr_scale = wr_ctrl || wr_cnt;
  assign pre_tick  = tick_i && ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_t'(wr_data_i[$bits(ctrl_t)-1:0]);
      if (wr_per)  period_q <= wr_data_i;
    end
  end

  tmr_prescaler u_pre (
    .clk_i, .rst_ni,
    .clr_i  (clr_scale),
    .tick_i (pre_tick),
    .sel_i  (ctrl_q.pre_sel),
    .step_o (step)
  );

  tmr_counter #(.W(DW)) u_cnt (
    .clk_i, .rst_ni,
    .load_i      (wr_cnt),
    .load_val_i  (wr_data_i),
    .step_i      (step),
    .period_i    (period_q),
    .cnt_o       (cnt),
    .match_evt_o (match_evt),
    .match_o     (match_o)
  );

  tmr_postscaler #(.SW($bits(ctrl_q.post_sel))) u_post (
    .clk_i, .rst_ni,
    .clr_i     (clr_scale),
    .match_i   (match_evt),
    .sel_i     (ctrl_q.post_sel),
    .irq_clr_i (irq_clr_i),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o = DW'(ctrl_q);
      ADDR_CNT:  rd_data_o = cnt;
      ADDR_PER:  rd_data_o = period_q;
      default:   rd_data_o = '0;
    endcase
  end

  // R4
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tick_i && ctrl_q.run) && !wr_cnt) |=> $stable(cnt));
  // R8
  ctrl_keeps_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl) |=> $stable(cnt));
endmodule

// File: tb/sim_tmr_period_match.sv
module sim_tmr_period_match;
  logic clk_i = 0, rst_ni = 0, tick_i = 0, wr_en_i = 0, irq_clr_i = 0;
  logic [1:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0, rd_data_o;
  logic irq_o, match_o;
  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  tmr_period_match u0 (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr_i = a; #0.5; v = rd_data_o;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #7 rst_ni = 1; step();
    // R1 reset values
    rd(2'd1, v); chk("R1 count", v, 8'h00);
    rd(2'd2, v); chk("R1 period", v, 8'hFF);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", irq_o, 0);
    chk("R1 match", match_o, 0);

    // R2 control bit 7 reads 0, address 3 reads 0
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 ctrl bit7", v, 8'h7F);
    wr(2'd3, 8'h55); rd(2'd3, v); chk("R2 addr3", v, 8'h00);
    wr(2'd0, 8'h00);

    // R4 disabled: count holds with tick high
    wr(2'd1, 8'h10); tick_i = 1;
    repeat (20) step();
    rd(2'd1, v); chk("R4 disabled hold", v, 8'h10);
    // R4 enabled but tick low: hold
    tick_i = 0; wr(2'd0, 8'h04);
    repeat (20) step();
    rd(2'd1, v); chk("R4 tick low hold", v, 8'h10);

    // R9 control write keeps count
    wr(2'd0, 8'h05); rd(2'd1, v); chk("R9 ctrl keeps count", v, 8'h10);

    // R9 count write wins over step (div 1, running)
    wr(2'd0, 8'h04); tick_i = 1;
    repeat (5) step();
    wr(2'd1, 8'h40); rd(2'd1, v); chk("R9 load priority", v, 8'h40);
    step(); rd(2'd1, v); chk("R5 increment", v, 8'h41);

    // R8 count write clears prescaler (div 4)
    wr(2'd0, 8'h05); step(); step();
    wr(2'd1, 8'h20);
    repeat (3) step(); rd(2'd1, v); chk("R8 prescaler cleared 3", v, 8'h20);
    step(); rd(2'd1, v); chk("R8 prescaler cleared 4", v, 8'h21);

    // R3/R5/R6 sweep
    for (int sel = 0; sel < 4; sel++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int qi = 0; qi < 4; qi++) begin
          int per, post, div, expn, n, nm;
          per  = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
          post = (qi == 0) ? 0 : (qi == 1) ? 1 : (qi == 2) ? 3 : 15;
          div  = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
          expn = div * (per + 1) * (post + 1);
          wr(2'd0, 8'h00);
          irq_clr_i = 1; wr(2'd1, 8'h00); irq_clr_i = 0;
          wr(2'd2, 8'(per));
          wr(2'd0, 8'((post << 3) | 4 | sel));
          n = 0; nm = 0;
          while (!irq_o && n < 5000) begin
            step(); n++;
            if (match_o) nm++;
          end
          chk($sformatf("R6 irq cycle sel=%0d per=%0d post=%0d", sel, per, post), n, expn);
          chk("R5 match pulses", nm, post + 1);
          if (sel == 3 && pi == 2 && qi == 0) begin
            rd(2'd1, v); chk("R5 count wraps to 0", v, 0);
          end
        end
      end
    end

    // R7 sticky, then clear
    wr(2'd0, 8'h00);
    repeat (10) step();
    chk("R7 sticky", irq_o, 1);
    irq_clr_i = 1; step(); irq_clr_i = 0;
    chk("R7 cleared", irq_o, 0);

    // R7 set wins over clear: period 0, div 1, post 1:1 -> set every step
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h04);
    irq_clr_i = 1; step(); step();
    chk("R7 set wins", irq_o, 1);
    irq_clr_i = 0;

    // R5 match_o single cycle when period large
    wr(2'd2, 8'h02); wr(2'd1, 8'h00); wr(2'd0, 8'h04);
    step(); step(); step();
    chk("R5 match high", match_o, 1);
    step(); chk("R5 match one cycle", match_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule